// File: doc/BRIEF.md
# Programmable Interval Timer Channel Set

This block holds three independent down-counting timer channels that share one count-tick enable. Each channel has a gate input and an output pin. Software-side logic programs a channel in a single write cycle with an operating mode, a byte-access mode and a 16-bit initial count. After that, the output pin follows one of six waveform rules. Each rule depends on how many ticks have elapsed since the count was loaded. Only clock edges on which the tick input is high count as ticks.

A latch command freezes a snapshot of a channel's counter value. A byte-wide read port returns either the snapshot or the live counter value, one byte per read cycle. The access mode chosen at load time decides which byte each read returns. The channels differ only in the reset level of their registered gate.

Top module: `pit_timer`

## Requirements
- R1: Mode 0 (terminal flag): the load forces the output low. The output rises on the edge where the elapsed tick count reaches the loaded count N, and stays high until the next load.
- R2: Mode 1 (retriggerable one-shot): the output is high while the elapsed ticks are below N and low afterwards. A low-to-high change of the gate pin restarts the elapsed count at zero.
- R3: Mode 2 (rate generator): the output is high only while the elapsed tick count is a nonzero multiple of N.
- R4: Mode 3 (square wave): within each period of N ticks, the output is high for the first (N+1)/2 ticks (integer division) and low for the rest. An odd N therefore gets the extra tick on the high side.
- R5: Modes 4 and 5 (strobes): the output is high only while the elapsed tick count equals N. In mode 5 a rising gate restarts the elapsed count, as in mode 1.
- R6: Mode codes 6 and 7 on the load port behave exactly as mode 0.
- R7: After reset, every channel is in mode 3 with N = 65536. All outputs are high, every counter reads 0x0000, the access mode is the alternating low/high pair, and rd_data is 0.
- R8: The registered gate resets to enabled on channels 0 and 1 and to disabled on channel 2. Channel 2 therefore ignores the first tick after reset, even when its gate pin is high.
- R9: A load count of 0 is taken as N = 65536.
- R10: The counter value is defined by mode. In modes 2 and 3 it is N minus (elapsed mod N). In the other modes it is N minus elapsed. Both are taken mod 65536. A latch command captures the value shown at that edge. The snapshot is returned by reads until its last byte is read; otherwise reads return the live value.
- R11: Access code 1 returns the low byte only. Code 2 returns the high byte only. Codes 0 and 3 alternate low byte, then high byte. A load restarts at the low byte and drops any pending snapshot.
- R12: In modes 0, 2, 3 and 4, ticks are ignored while the registered gate is low. In modes 1 and 5, the gate level does not stop counting.
- R13: A latch command that arrives while a snapshot is still pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-tick enable shared by all channels |
| gate_in | input | 3 | Gate pin per channel |
| wr_en | input | 1 | Load strobe for the channel in wr_ch |
| wr_ch | input | 2 | Channel to load |
| wr_mode | input | 3 | Operating mode code |
| wr_acc | input | 2 | Byte-access code |
| wr_count | input | 16 | Initial count (0 means 65536) |
| latch_cmd | input | 3 | Latch command per channel |
| rd_en | input | 1 | Read strobe for the channel in rd_ch |
| rd_ch | input | 2 | Channel to read |
| rd_data | output | 8 | Registered read byte |
| tmr_out | output | 3 | Registered output pin per channel |

## Verification
A load, a restart or a counted tick changes a channel's state at the sampling edge, and tmr_out shows the new waveform level right after that same edge. A gate pin change takes effect on counting one edge later, because the gate is registered. rd_data and a latch snapshot likewise settle at the edge that samples rd_en or latch_cmd. The bench updates its behavioural model at each rising edge with the inputs driven half a cycle before, and compares every output on the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_RETRIG   = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } pit_mode_e;

  typedef enum logic [1:0] {
    ACC_PAIR0 = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_PAIR  = 2'd3
  } pit_acc_e;

  // Codes above 5 fall back to the terminal-flag mode
  function automatic pit_mode_e norm_mode(input logic [2:0] code);
    return (code > 3'd5) ? M_TERM : pit_mode_e'(code);
  endfunction

  // Modes whose count restarts on a rising gate and ignores gate level
  function automatic logic is_trig(input pit_mode_e m);
    return (m == M_RETRIG) || (m == M_HWSTROBE);
  endfunction

  function automatic logic is_periodic(input pit_mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

endpackage

// File: rtl/pit_wave.sv
module pit_wave
  import pit_pkg::*;
#(
  parameter int CW = 16,
  parameter int EW = CW + 2
) (
  input  pit_mode_e        mode,
  input  logic [CW:0]      n,
  input  logic [EW-1:0]    e,
  input  logic [CW-1:0]    ph,
  output logic             lvl,
  output logic [CW-1:0]    cur
);
  logic [CW+1:0] half;
  logic [EW-1:0] n_x;

  assign half = ({1'b0, n} + (CW+2)'(1)) >> 1;
  assign n_x  = EW'(n);

  always_comb begin
    case (mode)
      M_TERM:   lvl = (e >= n_x);
      M_RETRIG: lvl = (e < n_x);
      M_RATE:   lvl = (ph == '0) && (e != '0);
      M_SQUARE: lvl = ((CW+2)'(ph) < half);
      default:  lvl = (e == n_x);
    endcase
  end

  // Counter value, modulo 2^CW
  assign cur = is_periodic(mode) ? (n[CW-1:0] - ph) : (n[CW-1:0] - e[CW-1:0]);

endmodule

// File: rtl/pit_readout.sv
module pit_readout
  import pit_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [1:0]    ld_acc,
  input  logic          rd,
  input  logic          latch,
  input  logic [CW-1:0] live,
  output logic [7:0]    byte_o
);
  localparam int RW = 16;

  pit_acc_e      acc_q;
  logic          ptr_q;
  logic          lvalid_q;
  logic [CW-1:0] lval_q;
  logic [RW-1:0] src;
  logic          pair;
  logic          done;

  assign src  = RW'(lvalid_q ? lval_q : live);
  assign pair = (acc_q == ACC_PAIR) || (acc_q == ACC_PAIR0);
  assign done = rd && (!pair || ptr_q);

  always_comb begin
    case (acc_q)
      ACC_LO:  byte_o = src[7:0];
      ACC_HI:  byte_o = src[15:8];
      default: byte_o = ptr_q ? src[15:8] : src[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= ACC_PAIR;
      ptr_q    <= 1'b0;
      lvalid_q <= 1'b0;
      lval_q   <= '0;
    end else if (ld) begin
      acc_q    <= pit_acc_e'(ld_acc);
      ptr_q    <= 1'b0;
      lvalid_q <= 1'b0;
    end else begin
      if (rd && pair) ptr_q <= ~ptr_q;
      if (latch && !lvalid_q) begin
        lvalid_q <= 1'b1;
        lval_q   <= live;
      end else if (done) begin
        lvalid_q <= 1'b0;
      end
    end
  end

  // R10/R13: a pending snapshot survives until read or reload
  assert_latch_hold_R10: assert property (@(posedge clk) disable iff (rst)
    lvalid_q && !rd && !ld |=> lvalid_q && $stable(lval_q));

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int   CW        = 16,
  parameter logic GATE_INIT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          gate,
  input  logic          ld,
  input  logic [2:0]    ld_mode,
  input  logic [1:0]    ld_acc,
  input  logic [CW-1:0] ld_count,
  input  logic          latch,
  input  logic          rd,
  output logic          out_q,
  output logic [7:0]    byte_o
);
  localparam int EW = CW + 2;

  pit_mode_e     mode_q, mode_n;
  logic [CW:0]   n_q, n_n;
  logic [EW-1:0] e_q, e_n, e_inc;
  logic [CW-1:0] ph_q, ph_n, ph_inc;
  logic [CW:0]   ph_p1;
  logic [CW-1:0] cur_n, cur_q;
  logic          gate_q, trig, rstrt, adv, lvl_n;

  assign trig   = is_trig(mode_q);
  assign rstrt  = trig && gate && !gate_q;
  assign adv    = tick && (trig || gate_q);
  assign e_inc  = (e_q == '1) ? e_q : e_q + EW'(1);
  assign ph_p1  = {1'b0, ph_q} + (CW+1)'(1);
  assign ph_inc = (ph_p1 == n_q) ? '0 : ph_p1[CW-1:0];

  always_comb begin
    mode_n = mode_q;
    n_n    = n_q;
    e_n    = e_q;
    ph_n   = ph_q;
    if (ld) begin
      mode_n = norm_mode(ld_mode);
      n_n    = {(ld_count == '0), ld_count};
      e_n    = '0;
      ph_n   = '0;
    end else if (rstrt) begin
      e_n    = '0;
      ph_n   = '0;
    end else if (adv) begin
      e_n    = e_inc;
      ph_n   = ph_inc;
    end
  end

  pit_wave #(.CW(CW), .EW(EW)) u_wave (
    .mode(mode_n), .n(n_n), .e(e_n), .ph(ph_n), .lvl(lvl_n), .cur(cur_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_SQUARE;
      n_q    <= {1'b1, {CW{1'b0}}};
      e_q    <= '0;
      ph_q   <= '0;
      gate_q <= GATE_INIT;
      out_q  <= 1'b1;
      cur_q  <= '0;
    end else begin
      mode_q <= mode_n;
      n_q    <= n_n;
      e_q    <= e_n;
      ph_q   <= ph_n;
      gate_q <= gate;
      out_q  <= lvl_n;
      cur_q  <= cur_n;
    end
  end

  pit_readout #(.CW(CW)) u_rd (
    .clk(clk), .rst(rst), .ld(ld), .ld_acc(ld_acc), .rd(rd),
    .latch(latch), .live(cur_q), .byte_o(byte_o)
  );

  assert_load_low_R1: assert property (@(posedge clk) disable iff (rst)
    ld && norm_mode(ld_mode) == M_TERM |=> !out_q);

  assert_retrig_stay_R2: assert property (@(posedge clk) disable iff (rst)
    mode_q == M_RETRIG && !out_q && !ld && !(gate && !gate_q) |=> !out_q);

  assert_rate_phase_R3: assert property (@(posedge clk) disable iff (rst)
    out_q && mode_q == M_RATE |-> ph_q == '0);

  assert_strobe_at_n_R5: assert property (@(posedge clk) disable iff (rst)
    out_q && (mode_q == M_SWSTROBE || mode_q == M_HWSTROBE) |-> e_q == EW'(n_q));

  assert_bad_code_R6: assert property (@(posedge clk) disable iff (rst)
    ld && ld_mode > 3'd5 |=> mode_q == M_TERM);

  assert_gate_pause_R12: assert property (@(posedge clk) disable iff (rst)
    !ld && !is_trig(mode_q) && !gate_q |=> $stable(e_q));

endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int             NCH      = 3,
  parameter int             CW       = 16,
  parameter logic [NCH-1:0] GATE_RST = NCH'(3),
  localparam int            CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [NCH-1:0] gate_in,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  logic [2:0]     wr_mode,
  input  logic [1:0]     wr_acc,
  input  logic [CW-1:0]  wr_count,
  input  logic [NCH-1:0] latch_cmd,
  input  logic           rd_en,
  input  logic [CHW-1:0] rd_ch,
  output logic [7:0]     rd_data,
  output logic [NCH-1:0] tmr_out
);
  logic [7:0] bytes [NCH];
  logic [7:0] sel_byte;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pit_channel #(.CW(CW), .GATE_INIT(GATE_RST[c])) u_ch (
      .clk(clk), .rst(rst), .tick(tick), .gate(gate_in[c]),
      .ld(wr_en && (wr_ch == CHW'(c))), .ld_mode(wr_mode),
      .ld_acc(wr_acc), .ld_count(wr_count), .latch(latch_cmd[c]),
      .rd(rd_en && (rd_ch == CHW'(c))), .out_q(tmr_out[c]),
      .byte_o(bytes[c])
    );
  end

  always_comb begin
    sel_byte = '0;
    for (int c = 0; c < NCH; c++)
      if (rd_ch == CHW'(c)) sel_byte = bytes[c];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel_byte;
  end

endmodule

// File: tb/sim_pit_timer.sv
module sim_pit_timer;
  logic       clk = 1'b0;
  logic       rst, tick, wr_en, rd_en;
  logic [2:0] gate_in, wr_mode, latch_cmd;
  logic [1:0] wr_ch, wr_acc, rd_ch;
  logic [15:0] wr_count;
  logic [7:0] rd_data;
  logic [2:0] tmr_out;

  always #4 clk = ~clk;

  pit_timer u0 (
    .clk(clk), .rst(rst), .tick(tick), .gate_in(gate_in), .wr_en(wr_en),
    .wr_ch(wr_ch), .wr_mode(wr_mode), .wr_acc(wr_acc), .wr_count(wr_count),
    .latch_cmd(latch_cmd), .rd_en(rd_en), .rd_ch(rd_ch), .rd_data(rd_data),
    .tmr_out(tmr_out)
  );

  int total = 0, bad = 0, cycles = 0;
  bit fin = 0;
  string tag = "R7";

  // behavioural reference model
  int m_mode[3], m_n[3], m_e[3], m_ph[3], m_gp[3];
  int m_acc[3], m_ptr[3], m_lv[3], m_lval[3], m_out[3];
  int exp_rd;
  bit rd_pend = 0;
  localparam int EMAX = 262143;

  function automatic int fout(int c);
    case (m_mode[c])
      0: return int'(m_e[c] >= m_n[c]);
      1: return int'(m_e[c] < m_n[c]);
      2: return int'(m_ph[c] == 0 && m_e[c] != 0);
      3: return int'(m_ph[c] < (m_n[c] + 1) / 2);
      default: return int'(m_e[c] == m_n[c]);
    endcase
  endfunction

  function automatic int fcur(int c);
    if (m_mode[c] == 2 || m_mode[c] == 3) return (m_n[c] - m_ph[c]) & 65535;
    return (m_n[c] - m_e[c]) & 65535;
  endfunction

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(posedge clk) begin
    rd_pend = 0;
    if (rst) begin
      for (int c = 0; c < 3; c++) begin
        m_mode[c] = 3; m_n[c] = 65536; m_e[c] = 0; m_ph[c] = 0;
        m_gp[c] = (c != 2); m_acc[c] = 3; m_ptr[c] = 0; m_lv[c] = 0;
        m_lval[c] = 0; m_out[c] = 1;
      end
    end else begin
      for (int c = 0; c < 3; c++) begin
        int cv, ov, src, done, trig;
        cv = fcur(c); ov = m_lv[c]; done = 0;
        trig = (m_mode[c] == 1 || m_mode[c] == 5);
        if (rd_en && rd_ch == c) begin
          src = ov ? m_lval[c] : cv;
          if (m_acc[c] == 1) exp_rd = src & 255;
          else if (m_acc[c] == 2) exp_rd = (src >> 8) & 255;
          else exp_rd = m_ptr[c] ? ((src >> 8) & 255) : (src & 255);
          rd_pend = 1;
          done = (m_acc[c] == 1 || m_acc[c] == 2 || m_ptr[c] == 1);
          if (m_acc[c] == 0 || m_acc[c] == 3) m_ptr[c] ^= 1;
        end
        if (latch_cmd[c] && !ov) begin m_lv[c] = 1; m_lval[c] = cv; end
        else if (done) m_lv[c] = 0;
        if (wr_en && wr_ch == c) begin
          m_mode[c] = (wr_mode > 5) ? 0 : int'(wr_mode);
          m_n[c] = (wr_count == 0) ? 65536 : int'(wr_count);
          m_acc[c] = wr_acc; m_ptr[c] = 0; m_lv[c] = 0;
          m_e[c] = 0; m_ph[c] = 0;
        end else if (trig && gate_in[c] && !m_gp[c]) begin
          m_e[c] = 0; m_ph[c] = 0;
        end else if (tick && (trig || m_gp[c])) begin
          if (m_e[c] < EMAX) m_e[c]++;
          m_ph[c] = (m_ph[c] + 1 == m_n[c]) ? 0 : m_ph[c] + 1;
        end
        m_gp[c] = gate_in[c];
        m_out[c] = fout(c);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !fin) begin
      for (int c = 0; c < 3; c++) chk(tag, int'(tmr_out[c]), m_out[c]);
      if (rd_pend) chk(tag, int'(rd_data), exp_rd);
    end
  end

  task automatic report();
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !fin) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      report();
    end
  end

  task automatic cyc(int k = 1); repeat (k) @(negedge clk); endtask
  task automatic load(int c, int md, int ac, int cnt);
    wr_en = 1; wr_ch = 2'(c); wr_mode = 3'(md); wr_acc = 2'(ac); wr_count = 16'(cnt);
    cyc(); wr_en = 0;
  endtask
  task automatic run(int k); tick = 1; cyc(k); tick = 0; endtask
  task automatic mixed(int k);
    for (int i = 0; i < k; i++) begin tick = (i % 3 != 0); cyc(); end
    tick = 0;
  endtask
  task automatic rdb(int c); rd_en = 1; rd_ch = 2'(c); cyc(); rd_en = 0; endtask
  task automatic lat(int c); latch_cmd = 3'(1 << c); cyc(); latch_cmd = 0; endtask

  initial begin
    rst = 1; tick = 0; gate_in = 3'b111; wr_en = 0; wr_ch = 0; wr_mode = 0;
    wr_acc = 0; wr_count = 0; latch_cmd = 0; rd_en = 0; rd_ch = 0;
    cyc(3);
    chk("R7", int'(tmr_out), 7);
    chk("R7", int'(rd_data), 0);
    rst = 0;
    tag = "R8"; run(3); rdb(0); rdb(0); rdb(2); rdb(2);   // ch2 lags one tick
    tag = "R7"; rdb(1); rdb(1);
    tag = "R9"; load(1, 2, 3, 0); rdb(1); rdb(1); run(2); rdb(1); rdb(1);
    tag = "R1"; load(0, 0, 3, 5); run(3); cyc(2); run(4); mixed(12);
    tag = "R2"; load(1, 1, 3, 4); run(6); gate_in[1] = 0; cyc(); gate_in[1] = 1; run(6);
    tag = "R3"; load(0, 2, 3, 3); mixed(14); load(0, 2, 3, 1); run(3);
    tag = "R4"; load(0, 3, 3, 5); run(12); load(0, 3, 3, 4); run(10); mixed(9);
    tag = "R5"; load(0, 4, 3, 3); run(6); load(1, 5, 3, 2); run(4);
    gate_in[1] = 0; cyc(); gate_in[1] = 1; run(4);
    tag = "R6"; load(0, 6, 3, 2); run(4); load(0, 7, 3, 3); run(5);
    tag = "R12"; load(0, 3, 3, 6); gate_in[0] = 0; run(5); gate_in[0] = 1; run(5);
    load(2, 2, 3, 4); gate_in[2] = 0; run(4); gate_in[2] = 1; run(6);
    load(1, 5, 3, 3); gate_in[1] = 0; run(5); gate_in[1] = 1; run(3);
    load(0, 0, 3, 4); gate_in[0] = 0; run(6); gate_in[0] = 1; run(5);
    tag = "R10"; load(0, 2, 3, 100); run(10); lat(0); run(5);
    rdb(0); rdb(0); rdb(0); rdb(0);
    tag = "R13"; lat(0); run(3); lat(0); run(2); rdb(0); rdb(0); rdb(0); rdb(0);
    tag = "R11"; load(0, 2, 1, 16'h1234); run(2); rdb(0); rdb(0);
    load(0, 2, 2, 16'h1234); rdb(0); rdb(0); lat(0); run(3); rdb(0); rdb(0);
    load(0, 2, 0, 16'h0300); run(1); rdb(0); rdb(0);
    load(0, 2, 3, 16'h0500); rdb(0); load(0, 2, 3, 16'h0600); rdb(0); rdb(0);
    cyc(2);
    report();
  end
endmodule